// File: doc/BRIEF.md
# Dual-Mode Asynchronous Register Bus Slave

This block gives an external processor read and write access to a bank of 8-bit control registers over an asynchronous parallel bus. One static mode input picks between two protocol families that share the same pins. In the first family, the processor pulses an active-high address latch and then uses separate active-low read and write strobes. In the second family, the processor holds an active-low address strobe for the whole cycle, uses an active-low data strobe to qualify the transfer, and uses a direction line to choose between read and write.

All bus pins are brought into the system clock domain through a synchronizer chain before the protocol logic sees them. Address and data travel through the same chain as the strobes, so every sampled address and data word stays aligned with the strobe edge it belongs to. The address is captured when the address strobe pin falls, and this holds in both modes. Writes commit when the write or data strobe deasserts. Read data comes from a registered read port and is driven onto a tri-state data bus only while the device is selected. A synchronous reset clears every register.

Top module: `regbus_async_slave`

## Requirements
- R1: While the reset input is high and afterwards, until a selected read, the data bus is not driven (`bus_drive` = 0). After reset every implemented register reads 0x00.
- R2: With `mode_sel` = 0 (strobe-pair mode), the address is captured on the falling edge of `strobe_a`, which is active high in this mode. Address bus changes while `strobe_a` stays low do not alter the target register.
- R3: With `mode_sel` = 0, while `cs_n` = 0 and `strobe_d_n` = 0 (read strobe), the addressed register is driven on `data_io`. After `strobe_d_n` returns high, `bus_drive` returns to 0.
- R4: With `mode_sel` = 0, a write of the `data_io` value present at the rising edge of `dir_wr` (active-low write strobe) is committed to the latched address, provided `cs_n` is low.
- R5: With `cs_n` high, no write takes effect and the bus is never driven, whatever the strobes do.
- R6: With `mode_sel` = 1 (strobe-direction mode), `strobe_a` is active low and the address is captured on its falling edge. A read is performed while `strobe_a`, `cs_n` and `strobe_d_n` are low and `dir_wr` = 1.
- R7: With `mode_sel` = 1 and `dir_wr` = 0, the data present when `strobe_d_n` rises is written to the captured address.
- R8: With `mode_sel` = 1, transfers complete correctly when `strobe_a` and `cs_n` are tied together and fall at the same time.
- R9: Addresses at or above `NUM_REGS` (default 96) read as 0x00 while the bus is driven. Writes to them change no register.
- R10: Both modes access the same register file. A value written in one mode is read back in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = strobe-pair protocol, 1 = strobe-direction protocol |
| cs_n | input | 1 | Active-low device select |
| strobe_a | input | 1 | Address strobe: active-high latch (mode 0), active-low strobe (mode 1) |
| strobe_d_n | input | 1 | Active-low read strobe (mode 0) or data strobe (mode 1) |
| dir_wr | input | 1 | Active-low write strobe (mode 0), or direction with 1 = read (mode 1) |
| addr | input | ADDR_W (7) | Register address |
| data_io | inout | DATA_W (8) | Bidirectional data bus |
| bus_drive | output | 1 | High while the block drives `data_io` |

## Verification
The assertions take for granted that each bus pin is held for at least three clock periods around every strobe edge. They also take for granted that address and data are stable from before the strobe edge that uses them until after it, and that `mode_sel` only changes while the bus is idle. The bench drives every pin on the falling clock edge and keeps each bus phase three to six cycles long, so each edge crosses the synchronizer cleanly. It changes the mode only after it has parked all pins at the idle levels of the new protocol. It releases the data bus only after the block has stopped driving it, so the two sides never drive at once.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic {
    MODE_PAIR = 1'b0,
    MODE_DIR  = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= rst_val;
        else     st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= rst_val;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_bit,
  input  logic              cs_n_c,
  input  logic              sa_c,
  input  logic              sd_n_c,
  input  logic              dw_c,
  input  logic [ADDR_W-1:0] addr_c,
  input  logic [DATA_W-1:0] data_c,
  output logic              oe_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  bus_mode_e         mode;
  logic              cs_n_p, sa_p, sd_n_p, dw_p;
  logic [ADDR_W-1:0] addr_lat;
  logic              addr_evt, rd_act;

  assign mode = bus_mode_e'(mode_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_p <= 1'b1;
      sa_p   <= 1'b0;
      sd_n_p <= 1'b1;
      dw_p   <= 1'b1;
    end else begin
      cs_n_p <= cs_n_c;
      sa_p   <= sa_c;
      sd_n_p <= sd_n_c;
      dw_p   <= dw_c;
    end
  end

  always_comb begin
    addr_evt = sa_p & ~sa_c;
    rd_act   = 1'b0;
    we       = 1'b0;
    unique case (mode)
      MODE_PAIR: begin
        rd_act = ~cs_n_c & ~sd_n_c;
        we     = ~cs_n_c & ~cs_n_p & ~dw_p & dw_c;
      end
      MODE_DIR: begin
        rd_act = ~cs_n_c & ~sa_c & ~sd_n_c & dw_c;
        we     = ~cs_n_p & ~sa_p & ~dw_p & ~sd_n_p & sd_n_c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lat <= '0;
      oe_q     <= 1'b0;
    end else begin
      if (addr_evt) addr_lat <= addr_c;
      oe_q <= rd_act;
    end
  end

  assign rd_addr = addr_evt ? addr_c : addr_lat;
  assign wr_addr = addr_lat;
  assign wr_data = data_c;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !oe_q);
  a_r2_addr_holds: assert property (@(posedge clk) disable iff (rst)
    !addr_evt |=> $stable(addr_lat));
  a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n_c |=> !oe_q);
  a_r4_single_commit: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_q
);
  localparam logic [ADDR_W:0] LIMIT = NUM_REGS[ADDR_W:0];

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              w_ok, r_ok;

  assign w_ok = ({1'b0, waddr} < LIMIT);
  assign r_ok = ({1'b0, raddr} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we && w_ok) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (r_ok) rd_q <= mem[raddr];
    else           rd_q <= '0;
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && w_ok) |=> (mem[$past(waddr)] == $past(wdata)));
  a_r9_unimpl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !r_ok |=> (rd_q == '0));
endmodule

// File: rtl/regbus_async_slave.sv
module regbus_async_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              strobe_a,
  input  logic              strobe_d_n,
  input  logic              dir_wr,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] data_io,
  output logic              bus_drive
);
  localparam int BW = 5 + ADDR_W + DATA_W;

  logic [BW-1:0]     raw_pins, sync_pins, pin_idle;
  logic              oe_q, we;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_q;

  assign raw_pins = {mode_sel, cs_n, strobe_a, strobe_d_n, dir_wr, addr, data_io};
  assign pin_idle = {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

  regbus_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rst_val(pin_idle), .d(raw_pins), .q(sync_pins)
  );

  regbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .mode_bit(sync_pins[BW-1]),
    .cs_n_c(sync_pins[BW-2]),
    .sa_c(sync_pins[BW-3]),
    .sd_n_c(sync_pins[BW-4]),
    .dw_c(sync_pins[BW-5]),
    .addr_c(sync_pins[DATA_W +: ADDR_W]),
    .data_c(sync_pins[DATA_W-1:0]),
    .oe_q(oe_q), .rd_addr(rd_addr), .we(we),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  regbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rd_q(rd_q)
  );

  assign bus_drive = oe_q & ~cs_n & ~rst;
  assign data_io   = bus_drive ? rd_q : {DATA_W{1'bz}};

  a_r1_reset_no_drive: assert property (@(posedge clk)
    rst |=> !oe_q);
endmodule

// File: tb/regbus_async_slave_test.sv
module regbus_async_slave_test;
  localparam int CLK_HALF = 5;
  localparam int NREG     = 96;

  logic clk = 1'b0;
  logic rst, mode_sel, cs_n, strobe_a, strobe_d_n, dir_wr;
  logic [6:0] addr;
  logic [7:0] tb_d;
  logic tb_en;
  wire  [7:0] data_bus;
  logic bus_drive;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model [128];

  logic [7:0] q_exp [$];
  bit         q_drv [$];
  string      q_tag [$];
  event       sample_ev;

  always #CLK_HALF clk = ~clk;
  assign data_bus = tb_en ? tb_d : 8'hzz;

  regbus_async_slave uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .strobe_a(strobe_a),
    .strobe_d_n(strobe_d_n), .dir_wr(dir_wr), .addr(addr), .data_io(data_bus),
    .bus_drive(bus_drive)
  );

  // monitor: pops expected items and compares with the bus
  initial begin
    forever begin
      @(sample_ev);
      begin
        logic [7:0] e;
        bit d;
        string t;
        e = q_exp.pop_front();
        d = q_drv.pop_front();
        t = q_tag.pop_front();
        n_cmp++;
        if (bus_drive !== d || (d && data_bus !== e)) begin
          n_bad++;
          $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                   t, bus_drive, data_bus, d, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input bit d, input logic [7:0] e, input string t);
    q_exp.push_back(e);
    q_drv.push_back(d);
    q_tag.push_back(t);
    -> sample_ev;
  endtask

  task automatic check_off(input string t);
    n_cmp++;
    if (bus_drive !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: drive=%0b expected drive=0", t, bus_drive);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [6:0] a);
    return (a < NREG) ? model[a] : 8'h00;
  endfunction

  task automatic pair_write(input logic [6:0] a, input logic [7:0] d, input bit sel);
    addr = a; strobe_a = 1'b1; cs_n = !sel;
    cyc(3); strobe_a = 1'b0;
    cyc(2); tb_d = d; tb_en = 1'b1; dir_wr = 1'b0;
    cyc(4); dir_wr = 1'b1;
    cyc(4); tb_en = 1'b0; cs_n = 1'b1;
    cyc(3);
    if (sel && a < NREG) model[a] = d;
  endtask

  task automatic pair_read(input logic [6:0] a, input bit sel, input bit scramble, input string t);
    addr = a; strobe_a = 1'b1; cs_n = !sel;
    cyc(3); strobe_a = 1'b0;
    cyc(2);
    if (scramble) addr = ~a;
    strobe_d_n = 1'b0;
    cyc(6); expect_item(sel, model_rd(a), t);
    cyc(1); strobe_d_n = 1'b1;
    cyc(5); check_off({t, " release"});
    cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic dir_write(input logic [6:0] a, input logic [7:0] d, input bit tied);
    addr = a; dir_wr = 1'b0; tb_d = d; tb_en = 1'b1;
    if (!tied) cs_n = 1'b0;
    cyc(2); strobe_a = 1'b0; cs_n = 1'b0;
    cyc(3); strobe_d_n = 1'b0;
    cyc(4); strobe_d_n = 1'b1;
    cyc(4); strobe_a = 1'b1; cs_n = 1'b1; tb_en = 1'b0; dir_wr = 1'b1;
    cyc(3);
    if (a < NREG) model[a] = d;
  endtask

  task automatic dir_read(input logic [6:0] a, input bit tied, input string t);
    addr = a; dir_wr = 1'b1;
    if (!tied) cs_n = 1'b0;
    cyc(2); strobe_a = 1'b0; cs_n = 1'b0;
    cyc(3); strobe_d_n = 1'b0;
    cyc(6); expect_item(1'b1, model_rd(a), t);
    cyc(1); strobe_d_n = 1'b1;
    cyc(5); check_off({t, " release"});
    strobe_a = 1'b1; cs_n = 1'b1;
    cyc(3);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    rst = 1'b1; mode_sel = 1'b0; cs_n = 1'b1; strobe_a = 1'b0;
    strobe_d_n = 1'b1; dir_wr = 1'b1; addr = '0; tb_d = '0; tb_en = 1'b0;
    cyc(3);
    check_off("R1 during reset");
    cyc(2); rst = 1'b0;
    cyc(4);
    check_off("R1 after reset");

    // R1: reset contents
    pair_read(7'd0,  1, 0, "R1 reg0 zero");
    pair_read(7'd37, 1, 0, "R1 reg37 zero");
    pair_read(7'd95, 1, 0, "R1 reg95 zero");

    // R4 / R3: strobe-pair writes and reads
    pair_write(7'd3,  8'hA5, 1);
    pair_write(7'd95, 8'h3C, 1);
    pair_write(7'd0,  8'hFF, 1);
    pair_read(7'd3,  1, 0, "R4 R3 reg3");
    pair_read(7'd95, 1, 0, "R4 R3 reg95");
    pair_read(7'd0,  1, 0, "R4 R3 reg0");

    // R2: address latched on strobe fall
    pair_read(7'd3, 1, 1, "R2 latched addr");

    // R5: deselected write ignored, deselected read not driven
    pair_write(7'd3, 8'h11, 0);
    pair_read(7'd3, 1, 0, "R5 write ignored");
    pair_read(7'd3, 0, 0, "R5 no drive");

    // R9: unimplemented address
    pair_write(7'd100, 8'h77, 1);
    pair_read(7'd100, 1, 0, "R9 reads zero");
    pair_read(7'd4, 1, 0, "R9 no alias");

    // switch to strobe-direction mode
    strobe_a = 1'b1; dir_wr = 1'b1; cyc(2);
    mode_sel = 1'b1; cyc(4);
    dir_read(7'd3, 0, "R6 R10 read reg3");
    dir_write(7'd10, 8'h5A, 0);
    dir_read(7'd10, 0, "R7 reg10");
    dir_write(7'd20, 8'hC3, 1);
    dir_read(7'd20, 1, "R8 tied reg20");
    dir_read(7'd10, 1, "R8 tied reg10");
    dir_write(7'd110, 8'h99, 0);
    dir_read(7'd110, 0, "R9 dir unimpl");

    // back to strobe-pair mode
    strobe_a = 1'b0; cyc(2);
    mode_sel = 1'b0; cyc(4);
    pair_read(7'd20, 1, 0, "R10 cross-mode reg20");
    pair_read(7'd14, 1, 0, "R9 R10 no alias of 110");

    cyc(4);
    done = 1;
    finish_run();
  end
endmodule